// File: doc/BRIEF.md
# Parking Address Bus Arbiter

This block decides which master owns a shared address bus. Master 0 is the internal master group; masters 1 to N_MST-1 are external devices. Each master raises a request line and receives a grant line. The arbiter moves grants only at the end of an address tenure, which it sees as the one-cycle address acknowledge strobe. Each new grant is therefore qualified: it appears one clock after that acknowledge. When nobody is asking for the bus, the grant rests on a configured parked master. That master can then start a tenure straight away without first raising a request, which saves one cycle.

The internal master's priority arrives with its request on `int_lvl`. Each external master's priority comes from a configuration field. A larger value wins, and equal values go to the lower index. The cycle after an acknowledge is the retry window. A retry seen there cancels the grant just issued: all grants are held low for one cycle, then requests are sampled again. A master may drop its request before it uses a grant. The arbiter then passes that grant on, so the bus is never stuck on an idle holder.

The controller has four states. `ST_PARK`: the grant rests on the parked master. `ST_OWN`: a requester holds the grant. `ST_WIN`: the retry window after an acknowledge. `ST_VOID`: a retry has cancelled the grant. Transitions:
- PARK→WIN and OWN→WIN on an acknowledge.
- PARK→OWN on any request.
- OWN→OWN when the holder withdraws and another master is requesting.
- OWN→PARK when the holder withdraws and no master is requesting.
- WIN→VOID on a retry.
- WIN→PARK or WIN→OWN with no retry, depending on whether the grant went to the parked master.
- VOID→OWN or VOID→PARK after requests are sampled again.

Top module: `abus_park_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the grant vector becomes the one-hot code of `cfg_park`, where bit i of `gnt` is master i and index 0 is the internal master.
- R2: At most one bit of `gnt` is high at any time.
- R3: With no requests and no acknowledge, the parked grant stays high, and it follows a change of `cfg_park` one edge later.
- R4: In the parked state, any request moves the grant to the arbitration winner at the next edge, with no acknowledge needed.
- R5: While the holder keeps its request high and no acknowledge arrives, the grant does not change, even when other masters request.
- R6: An acknowledge in the parked or owned state grants, one edge later, the requester with the largest priority. Master 0's priority is `int_lvl`. Master i≥1 uses `cfg_ext_prio[(i-1)*PRIO_W +: PRIO_W]`.
- R7: Among requesters with equal priority, the lowest index wins.
- R8: An acknowledge with no request pending gives the grant to the parked master one edge later.
- R9: `artry` high in the cycle after an acknowledge drives all grants low at the next edge. Requests sampled in that low cycle decide the grant at the edge after.
- R10: If the holder drops its request without an acknowledge, the grant moves at the next edge to the winner among the other requesters, or to the parked master if there are none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N_MST | Request per master, bit 0 internal |
| int_lvl | input | PRIO_W | Priority level carried with the internal request |
| cfg_ext_prio | input | (N_MST-1)*PRIO_W | Priority field per external master |
| cfg_park | input | $clog2(N_MST) | Index of the parked master |
| aack | input | 1 | Address acknowledge strobe ending a tenure |
| artry | input | 1 | Address retry strobe |
| gnt | output | N_MST | Grant per master, one-hot or zero |

## Verification
The selection logic is driven with three kinds of request set at an acknowledge. Distinct external levels show that the field position for each master is right. A high internal level against externals shows that `int_lvl` is used for master 0. Equal levels isolate the tie rule. Requests that arrive mid-tenure, with the holder still asking, separate "move only at acknowledge" from the free movement allowed when parked or after a withdrawal. Acknowledges with no requests, a retry in the window, and a change of park index while idle tell apart the three routes back to a grant: parking, cancellation, and configuration tracking.

// File: rtl/abus_arb_pkg.sv
package abus_arb_pkg;

    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_OWN  = 2'd1,
        ST_WIN  = 2'd2,
        ST_VOID = 2'd3
    } arb_state_e;

endpackage

// File: rtl/abus_arb_pick.sv
module abus_arb_pick #(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 2
) (
    input  logic [N_MST-1:0]        req,
    input  logic [N_MST*PRIO_W-1:0] prio,
    output logic [N_MST-1:0]        win_oh,
    output logic                    any_req
);
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

    logic [IDX_W-1:0]  best_idx;
    logic [PRIO_W-1:0] best_lvl;
    logic              found;

    // strict greater-than keeps the lowest index on equal levels
    always_comb begin
        best_idx = '0;
        best_lvl = '0;
        found    = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (req[i] && (!found || prio[i*PRIO_W +: PRIO_W] > best_lvl)) begin
                best_idx = IDX_W'(i);
                best_lvl = prio[i*PRIO_W +: PRIO_W];
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_MST; i++) begin
            win_oh[i] = found && (best_idx == IDX_W'(i));
        end
    end

    assign any_req = found;

endmodule

// File: rtl/abus_arb_park_dec.sv
module abus_arb_park_dec #(
    parameter int N_MST = 4,
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] park_idx,
    output logic [N_MST-1:0] park_oh
);
    for (genvar g = 0; g < N_MST; g++) begin : g_dec
        assign park_oh[g] = (park_idx == IDX_W'(g));
    end
endmodule

// File: rtl/abus_park_arbiter.sv
module abus_park_arbiter
    import abus_arb_pkg::*;
#(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 2,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1,
    localparam int EXT_W = (N_MST > 1) ? (N_MST-1)*PRIO_W : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MST-1:0]  req,
    input  logic [PRIO_W-1:0] int_lvl,
    input  logic [EXT_W-1:0]  cfg_ext_prio,
    input  logic [IDX_W-1:0]  cfg_park,
    input  logic              aack,
    input  logic              artry,
    output logic [N_MST-1:0]  gnt
);

    logic [N_MST*PRIO_W-1:0] prio_all;
    logic [N_MST-1:0]        win_oh;
    logic [N_MST-1:0]        park_oh;
    logic                    any_req;

    arb_state_e       st, st_n;
    logic [N_MST-1:0] gnt_n;
    logic             on_park, on_park_n;
    logic [N_MST-1:0] sel_oh;
    logic             hold_req;

    // priority vector: internal level first, then external fields
    assign prio_all[PRIO_W-1:0] = int_lvl;
    for (genvar g = 1; g < N_MST; g++) begin : g_prio
        assign prio_all[g*PRIO_W +: PRIO_W] = cfg_ext_prio[(g-1)*PRIO_W +: PRIO_W];
    end

    abus_arb_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_pick (
        .req     (req),
        .prio    (prio_all),
        .win_oh  (win_oh),
        .any_req (any_req)
    );

    abus_arb_park_dec #(.N_MST(N_MST), .IDX_W(IDX_W)) u_park (
        .park_idx (cfg_park),
        .park_oh  (park_oh)
    );

    assign sel_oh   = any_req ? win_oh : park_oh;
    assign hold_req = |(req & gnt);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_PARK;
            gnt     <= park_oh;
            on_park <= 1'b1;
        end else begin
            st      <= st_n;
            gnt     <= gnt_n;
            on_park <= on_park_n;
        end
    end

    // next state and next grant
    always_comb begin
        st_n      = st;
        gnt_n     = gnt;
        on_park_n = on_park;
        unique case (st)
            ST_PARK: begin
                if (aack) begin
                    gnt_n     = sel_oh;
                    on_park_n = !any_req;
                    st_n      = ST_WIN;
                end else if (any_req) begin
                    gnt_n     = win_oh;
                    on_park_n = 1'b0;
                    st_n      = ST_OWN;
                end else begin
                    gnt_n     = park_oh;
                    on_park_n = 1'b1;
                end
            end
            ST_OWN: begin
                if (aack) begin
                    gnt_n     = sel_oh;
                    on_park_n = !any_req;
                    st_n      = ST_WIN;
                end else if (!hold_req) begin
                    gnt_n     = sel_oh;
                    on_park_n = !any_req;
                    st_n      = any_req ? ST_OWN : ST_PARK;
                end
            end
            ST_WIN: begin
                if (artry) begin
                    gnt_n = '0;
                    st_n  = ST_VOID;
                end else begin
                    st_n = on_park ? ST_PARK : ST_OWN;
                end
            end
            ST_VOID: begin
                gnt_n     = sel_oh;
                on_park_n = !any_req;
                st_n      = any_req ? ST_OWN : ST_PARK;
            end
        endcase
    end

    // checks beside the logic they guard
    assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OWN && !aack && hold_req) |=> $stable(gnt));

    assert_ack_to_requester_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_OWN || st == ST_PARK) && aack && (|req)) |=> (|(gnt & $past(req))));

    assert_ack_idle_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_OWN || st == ST_PARK) && aack && req == '0) |=> (gnt == $past(park_oh)));

    assert_retry_voids_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WIN && artry) |=> (gnt == '0));

endmodule

// File: tb/sim_abus_park_arbiter.sv
`timescale 1ns/1ps
module sim_abus_park_arbiter;
    localparam int N = 4;
    localparam int PW = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [PW-1:0] int_lvl = '0;
    logic [5:0]   cfg_ext_prio = '0;
    logic [1:0]   cfg_park = '0;
    logic         aack = 1'b0;
    logic         artry = 1'b0;
    logic [N-1:0] gnt;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    abus_park_arbiter #(.N_MST(N), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .int_lvl(int_lvl),
        .cfg_ext_prio(cfg_ext_prio), .cfg_park(cfg_park),
        .aack(aack), .artry(artry), .gnt(gnt)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input logic [N-1:0] exp, input string tag);
        total++;
        if (gnt !== exp) begin
            bad++;
            $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
        end
        total++;
        if ($countones(gnt) > 1) begin
            bad++;
            $display("FAIL R2: gnt=%b expected at most one bit", gnt);
        end
    endtask

    task automatic do_reset(input logic [1:0] park);
        rst_n = 1'b0; req = '0; aack = 1'b0; artry = 1'b0;
        cfg_park = park; int_lvl = '0; cfg_ext_prio = '0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // R1 and R3: reset state and idle parking
    task automatic t_reset_park();
        do_reset(2'd2);
        chk(4'b0100, "R1 reset parks on cfg index");
        tick(); tick(); tick();
        chk(4'b0100, "R3 parked grant held while idle");
        cfg_park = 2'd1;
        tick();
        chk(4'b0010, "R3 parked grant follows cfg change");
    endtask

    // R4, R5, R6 basic movement
    task automatic t_move();
        do_reset(2'd0);
        req = 4'b1000;
        tick();
        chk(4'b1000, "R4 request takes parked grant");
        req = 4'b1010;
        tick(); tick();
        chk(4'b1000, "R5 grant held until ack");
        req = 4'b0010; aack = 1'b1;
        tick();
        aack = 1'b0;
        chk(4'b0010, "R6 grant after ack");
        tick();
        chk(4'b0010, "R6 grant kept after window");
    endtask

    // R6, R7 priority and ties
    task automatic t_prio();
        do_reset(2'd0);
        cfg_ext_prio = {2'd3, 2'd1, 2'd0}; // m3=3 m2=1 m1=0
        int_lvl = 2'd2;
        req = 4'b0010;
        tick();
        chk(4'b0010, "R4 setup owner m1");
        req = 4'b1100; aack = 1'b1;
        tick();
        aack = 1'b0;
        chk(4'b1000, "R6 external field levels");
        tick();
        req = 4'b0101; aack = 1'b1;
        tick();
        aack = 1'b0;
        chk(4'b0001, "R6 internal level wins");
        tick();
        cfg_ext_prio = {2'd0, 2'd2, 2'd2}; int_lvl = 2'd0;
        req = 4'b0111; aack = 1'b1;
        tick();
        aack = 1'b0;
        chk(4'b0010, "R7 tie goes to lower index");
    endtask

    // R8 park on idle ack
    task automatic t_idle_ack();
        do_reset(2'd3);
        req = 4'b0100;
        tick();
        chk(4'b0100, "R4 setup owner m2");
        req = 4'b0000; aack = 1'b1;
        tick();
        aack = 1'b0;
        chk(4'b1000, "R8 idle ack parks external");
        tick(); tick();
        chk(4'b1000, "R3 parked without request");
    endtask

    // R9 retry window
    task automatic t_retry();
        do_reset(2'd0);
        cfg_ext_prio = {2'd0, 2'd0, 2'd3};
        req = 4'b0010;
        tick();
        req = 4'b0100; aack = 1'b1;
        tick();
        aack = 1'b0;
        chk(4'b0100, "R9 grant in window");
        artry = 1'b1;
        tick();
        artry = 1'b0;
        chk(4'b0000, "R9 retry clears grants");
        req = 4'b0110;
        tick();
        chk(4'b0010, "R9 resample after retry");
    endtask

    // R10 withdrawal
    task automatic t_withdraw();
        do_reset(2'd1);
        req = 4'b0100;
        tick();
        chk(4'b0100, "R4 setup owner m2");
        req = 4'b1000;
        tick();
        chk(4'b1000, "R10 withdraw passes to other");
        req = 4'b0000;
        tick();
        chk(4'b0010, "R10 withdraw with none parks");
    endtask

    initial begin
        t_reset_park();
        t_move();
        t_prio();
        t_idle_ack();
        t_retry();
        t_withdraw();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule